// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block is a two-dimensional drawing engine for a frame buffer holding 16-bit pixels. A host pushes 32-bit command words into it, one per accepted handshake. Most words load a drawing parameter: destination start address, source start address, rectangle width, rectangle height or fill colour. Two start words launch work. One paints the rectangle with the stored colour. The other copies a same-sized rectangle from the source area to the destination area, walking columns and rows in a direction the start word selects.

The engine reaches the frame buffer through a single-port memory interface that takes one word request per cycle. A read returns its data on `mem_rdata` in the cycle after the request. Each row of the rectangle sits one line pitch (in bytes, given on `line_pitch`) below the previous row. While a rectangle is being drawn the engine holds `busy` high and refuses further command words. One cycle after the last pixel write it pulses `done`, and it also pulses `irq` if the start word asked for an interrupt.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `done`, `irq` and `mem_req` are low and `cmd_ready` is high.
- R2: A command word carries its opcode in bits 31:24. Opcode 0x0C loads the destination start address and opcode 0x0D loads the source start address, each from bits 23:0 as a byte address whose bit 0 is forced to zero.
- R3: Opcode 0x0E loads the width and opcode 0x0F loads the height, each from bits 9:0 and each encoded as the pixel count minus one.
- R4: Opcode 0x0B loads the colour from bits 15:0. Opcode 0x23 then writes that colour to every pixel of the rectangle, one write per cycle. The pixel at column x and row y sits at byte address base + y*pitch + 2*x.
- R5: Opcode 0x21 copies the rectangle pixel by pixel. Each pixel takes one read at the source address, followed in the next cycle by a write of the returned data at the matching destination address.
- R6: The default order is row by row from the top row, and within each row from left to right. In a copy start word, bit 5 set walks each row from right to left and bit 4 set starts at the bottom row. Source and destination follow the same order.
- R7: `busy` rises in the cycle after a start word is accepted and stays high for exactly W*H cycles for a fill and 2*W*H cycles for a copy. `cmd_ready` stays low for as long as `busy` is high.
- R8: `done` is a one-cycle pulse in the cycle right after the final pixel write, exactly once per start word.
- R9: `irq` pulses together with `done` only when bit 1 of the start word was set. Bit 0 (end of command) is accepted but does not change how the rectangle is drawn.
- R10: A word with any other opcode is consumed and changes no stored parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_data | input | 32 | Command word: opcode in bits 31:24, parameter in the low bits |
| cmd_ready | output | 1 | Command word can be accepted (high when idle) |
| line_pitch | input | 16 | Byte distance between vertically adjacent pixels |
| mem_req | output | 1 | Frame-buffer access this cycle |
| mem_we | output | 1 | Access is a write (1) or a read (0) |
| mem_addr | output | 24 | Frame-buffer byte address, always even |
| mem_wdata | output | 16 | Pixel written |
| mem_rdata | input | 16 | Pixel read, valid the cycle after the read request |
| busy | output | 1 | Rectangle operation in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion pulse for start words that requested an interrupt |

## Verification
The assertions assume that the memory answers every read in the very next cycle. They also assume that `line_pitch` is even and does not change while `busy` is high. The bench's memory model registers read data on the request edge, and the bench changes the pitch only between rectangles. The bench offers command words only while the engine is idle, and it always holds a word until the engine accepts it. For that reason the sequencing checks never see a parameter change in the middle of a rectangle.

// File: rtl/blit_pkg.sv
package blit_pkg;
   localparam int CMD_W = 32;
   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OP_COLOR   = 8'h0B;
   localparam logic [OPC_W-1:0] OP_DST     = 8'h0C;
   localparam logic [OPC_W-1:0] OP_SRC     = 8'h0D;
   localparam logic [OPC_W-1:0] OP_WIDTH   = 8'h0E;
   localparam logic [OPC_W-1:0] OP_HEIGHT  = 8'h0F;
   localparam logic [OPC_W-1:0] OP_GO_COPY = 8'h21;
   localparam logic [OPC_W-1:0] OP_GO_FILL = 8'h23;

   localparam int GO_IRQ_BIT  = 1;
   localparam int GO_VREV_BIT = 4;
   localparam int GO_HREV_BIT = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } blit_state_e;
endpackage

// File: rtl/blit_cmd_decode.sv
module blit_cmd_decode
   import blit_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int PIX_W  = 16,
   parameter int DIM_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CMD_W-1:0]  word,
   output logic [ADDR_W-1:0] dst_base,
   output logic [ADDR_W-1:0] src_base,
   output logic [DIM_W-1:0]  wid_m1,
   output logic [DIM_W-1:0]  hgt_m1,
   output logic [PIX_W-1:0]  color,
   output logic              go,
   output logic              go_copy,
   output logic              go_irq,
   output logic              go_hrev,
   output logic              go_vrev
);
   localparam int PARAM_W = CMD_W - OPC_W;

   if (ADDR_W > PARAM_W || PIX_W > PARAM_W || DIM_W > PARAM_W) begin : g_bad_width
      $error("blit_cmd_decode: a field does not fit below the opcode");
   end

   logic [OPC_W-1:0] opc;
   logic             known;
   logic             unused_word;

   assign opc         = word[CMD_W-1:CMD_W-OPC_W];
   assign unused_word = ^word;

   always_comb begin
      case (opc)
         OP_COLOR, OP_DST, OP_SRC, OP_WIDTH, OP_HEIGHT,
         OP_GO_COPY, OP_GO_FILL: known = 1'b1;
         default:                known = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_base <= '0;
         src_base <= '0;
         wid_m1   <= '0;
         hgt_m1   <= '0;
         color    <= '0;
      end else if (accept) begin
         case (opc)
            OP_DST:    dst_base <= {word[ADDR_W-1:1], 1'b0};
            OP_SRC:    src_base <= {word[ADDR_W-1:1], 1'b0};
            OP_WIDTH:  wid_m1   <= word[DIM_W-1:0];
            OP_HEIGHT: hgt_m1   <= word[DIM_W-1:0];
            OP_COLOR:  color    <= word[PIX_W-1:0];
            default: ;
         endcase
      end
   end

   assign go      = accept && (opc == OP_GO_FILL || opc == OP_GO_COPY);
   assign go_copy = (opc == OP_GO_COPY);
   assign go_irq  = word[GO_IRQ_BIT];
   assign go_hrev = go_copy && word[GO_HREV_BIT];
   assign go_vrev = go_copy && word[GO_VREV_BIT];

   AST_UNKNOWN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !known) |=> ($stable(dst_base) && $stable(src_base) && $stable(wid_m1)
                              && $stable(hgt_m1) && $stable(color))); // R10
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
   parameter int ADDR_W  = 24,
   parameter int DIM_W   = 10,
   parameter int PITCH_W = 16
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [PITCH_W-1:0] pitch,
   input  logic [DIM_W-1:0]   x,
   input  logic [DIM_W-1:0]   y,
   output logic [ADDR_W-1:0]  addr
);
   localparam int SUM_W = ADDR_W + DIM_W + PITCH_W + 1;

   logic [SUM_W-1:0] sum;
   logic             unused_sum;

   assign sum        = SUM_W'(base) + SUM_W'(y) * SUM_W'(pitch) + SUM_W'({x, 1'b0});
   assign addr       = {sum[ADDR_W-1:1], 1'b0};
   assign unused_sum = ^sum;
endmodule

// File: rtl/blit_walker.sv
module blit_walker
   import blit_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int PIX_W   = 16,
   parameter int DIM_W   = 10,
   parameter int PITCH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_copy,
   input  logic               start_irq,
   input  logic               start_hrev,
   input  logic               start_vrev,
   input  logic [ADDR_W-1:0]  dst_base,
   input  logic [ADDR_W-1:0]  src_base,
   input  logic [DIM_W-1:0]   wid_m1,
   input  logic [DIM_W-1:0]   hgt_m1,
   input  logic [PIX_W-1:0]   color,
   input  logic [PITCH_W-1:0] pitch,
   input  logic [PIX_W-1:0]   mem_rdata,
   output logic               busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [PIX_W-1:0]   mem_wdata,
   output logic               done,
   output logic               irq
);
   localparam int N_PORTS = 2;   // 0: destination, 1: source

   blit_state_e       state;
   logic [DIM_W-1:0]  col, row, px, py;
   logic              hrev, vrev, irq_en;
   logic              last_col, last_row, advance;
   logic [ADDR_W-1:0] bases   [N_PORTS];
   logic [ADDR_W-1:0] ag_addr [N_PORTS];

   assign px       = hrev ? (wid_m1 - col) : col;
   assign py       = vrev ? (hgt_m1 - row) : row;
   assign bases[0] = dst_base;
   assign bases[1] = src_base;

   for (genvar g = 0; g < N_PORTS; g++) begin : g_port
      blit_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_ag (
         .base (bases[g]),
         .pitch(pitch),
         .x    (px),
         .y    (py),
         .addr (ag_addr[g])
      );
   end

   assign last_col  = (col == wid_m1);
   assign last_row  = (row == hgt_m1);
   assign advance   = (state == ST_FILL) || (state == ST_WR);
   assign busy      = (state != ST_IDLE);
   assign mem_req   = busy;
   assign mem_we    = advance;
   assign mem_addr  = (state == ST_RD) ? ag_addr[1] : ag_addr[0];
   assign mem_wdata = (state == ST_FILL) ? color : mem_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         col    <= '0;
         row    <= '0;
         hrev   <= 1'b0;
         vrev   <= 1'b0;
         irq_en <= 1'b0;
         done   <= 1'b0;
         irq    <= 1'b0;
      end else begin
         done <= 1'b0;
         irq  <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state  <= start_copy ? ST_RD : ST_FILL;
               col    <= '0;
               row    <= '0;
               hrev   <= start_hrev;
               vrev   <= start_vrev;
               irq_en <= start_irq;
            end
            ST_RD: state <= ST_WR;
            default: ;
         endcase
         if (advance) begin
            if (last_col) begin
               col <= '0;
               row <= row + DIM_W'(1);
            end else begin
               col <= col + DIM_W'(1);
            end
            if (last_col && last_row) begin
               state <= ST_IDLE;
               done  <= 1'b1;
               irq   <= irq_en;
            end else if (state == ST_WR) begin
               state <= ST_RD;
            end
         end
      end
   end

   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_req && mem_we)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_COPY_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR) |-> $past(mem_req && !mem_we)); // R5
   AST_IRQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(busy)); // R9
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int PIX_W   = 16,
   parameter int DIM_W   = 10,
   parameter int PITCH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [31:0]        cmd_data,
   output logic               cmd_ready,
   input  logic [PITCH_W-1:0] line_pitch,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [PIX_W-1:0]   mem_wdata,
   input  logic [PIX_W-1:0]   mem_rdata,
   output logic               busy,
   output logic               done,
   output logic               irq
);
   if (CMD_W != 32) begin : g_bad_cmd
      $error("blit_engine: command words must be 32 bits");
   end

   logic              accept, go, go_copy, go_irq, go_hrev, go_vrev;
   logic [ADDR_W-1:0] dst_base, src_base;
   logic [DIM_W-1:0]  wid_m1, hgt_m1;
   logic [PIX_W-1:0]  color;

   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready;

   blit_cmd_decode #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .DIM_W(DIM_W)) u_dec (
      .clk, .rst_n, .accept, .word(cmd_data),
      .dst_base, .src_base, .wid_m1, .hgt_m1, .color,
      .go, .go_copy, .go_irq, .go_hrev, .go_vrev
   );

   blit_walker #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) u_walk (
      .clk, .rst_n,
      .start(go), .start_copy(go_copy), .start_irq(go_irq),
      .start_hrev(go_hrev), .start_vrev(go_vrev),
      .dst_base, .src_base, .wid_m1, .hgt_m1, .color,
      .pitch(line_pitch), .mem_rdata,
      .busy, .mem_req, .mem_we, .mem_addr, .mem_wdata, .done, .irq
   );

   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> busy); // R7
   AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[0] == 1'b0)); // R2
endmodule

// File: tb/tb_blit_engine.sv
`timescale 1ns/1ps
module tb_blit_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_data = '0;
   logic        cmd_ready;
   logic [15:0] line_pitch = 16'd32;
   logic        mem_req, mem_we;
   logic [23:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        busy, done, irq;

   always #10 clk = ~clk;   // 50 MHz

   blit_engine dut (
      .clk, .rst_n, .cmd_valid, .cmd_data, .cmd_ready, .line_pitch,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
      .busy, .done, .irq
   );

   logic [15:0] mem [0:2047];
   int checks = 0, errors = 0;
   int cyc = 0, wr_cnt = 0, last_wr_cyc = 0, done_cnt = 0, done_cyc = 0;
   int irq_cnt = 0, busy_cnt = 0, ready_busy = 0;
   int first_wr_addr = -1;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && mem_we) begin
         mem[mem_addr[11:1]] <= mem_wdata;
         if (wr_cnt == 0) first_wr_addr <= int'(mem_addr);
         wr_cnt      <= wr_cnt + 1;
         last_wr_cyc <= cyc;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:1]];
      if (done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
      if (irq) irq_cnt <= irq_cnt + 1;
      if (busy) busy_cnt <= busy_cnt + 1;
      if (busy && cmd_ready) ready_busy <= ready_busy + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      @(negedge clk);
      wr_cnt = 0; done_cnt = 0; irq_cnt = 0; busy_cnt = 0; ready_busy = 0;
      first_wr_addr = -1;
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = w;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
   endtask

   function automatic int px_word(input int base, input int x, input int y);
      return ((base + y * 32 + x * 2) >> 1) & 2047;
   endfunction

   task automatic t_reset();
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 mem_req", int'(mem_req), 0);
      chk("R1 cmd_ready", int'(cmd_ready), 1);
   endtask

   task automatic t_fill_irq();
      int bad = 0;
      for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
      clear_stats();
      send(32'h0C00_0100); send(32'h0E00_0003); send(32'h0F00_0002);
      send(32'h0B00_F81F); send(32'h2300_0003);
      wait_done();
      for (int y = 0; y < 3; y++)
         for (int x = 0; x < 4; x++)
            if (mem[px_word(32'h100, x, y)] != 16'hF81F) bad++;
      chk("R4 fill pixels", bad, 0);
      chk("R4 right neighbour untouched", int'(mem[px_word(32'h100, 4, 0)]), 0);
      chk("R3 row below untouched", int'(mem[px_word(32'h100, 0, 3)]), 0);
      chk("R4 write count", wr_cnt, 12);
      chk("R7 fill busy cycles", busy_cnt, 12);
      chk("R7 ready low while busy", ready_busy, 0);
      chk("R8 done count", done_cnt, 1);
      chk("R8 done timing", done_cyc, last_wr_cyc + 1);
      chk("R9 irq requested", irq_cnt, 1);
   endtask

   task automatic t_fill_noirq();
      int bad = 0;
      clear_stats();
      send(32'h0C00_0300); send(32'h0E00_0001); send(32'h0F00_0001);
      send(32'h0B00_07E0); send(32'h2300_0001);
      wait_done();
      for (int y = 0; y < 2; y++)
         for (int x = 0; x < 2; x++)
            if (mem[px_word(32'h300, x, y)] != 16'h07E0) bad++;
      chk("R4 second fill", bad, 0);
      chk("R9 no irq without bit 1", irq_cnt, 0);
      chk("R8 done once", done_cnt, 1);
   endtask

   task automatic t_copy(input logic [31:0] go, input int dst, input int exp_first, input string tag);
      int bad = 0;
      for (int y = 0; y < 2; y++)
         for (int x = 0; x < 3; x++) begin
            mem[px_word(32'h400, x, y)] = 16'(16'h1000 + y * 16 + x);
            mem[px_word(dst, x, y)] = 16'h0;
         end
      clear_stats();
      send(32'h0D00_0400); send({8'h0C, 24'(dst)});
      send(32'h0E00_0002); send(32'h0F00_0001); send(go);
      wait_done();
      for (int y = 0; y < 2; y++)
         for (int x = 0; x < 3; x++)
            if (mem[px_word(dst, x, y)] != 16'(16'h1000 + y * 16 + x)) bad++;
      chk({tag, " copy data R5"}, bad, 0);
      chk({tag, " first write R6"}, first_wr_addr, exp_first);
      chk({tag, " busy cycles R7"}, busy_cnt, 12);
      chk({tag, " writes R5"}, wr_cnt, 6);
   endtask

   task automatic t_unknown();
      clear_stats();
      mem[12'hABC >> 1] = 16'h0;
      send(32'h0C00_0C00); send(32'h0B00_1234);
      send(32'h0E00_0000); send(32'h0F00_0000);
      send(32'h5500_0ABC); send(32'h0A00_FFFF); send(32'h1000_0123);
      send(32'h2300_0000);
      wait_done();
      chk("R10 colour and address kept", int'(mem[12'hC00 >> 1]), 16'h1234);
      chk("R10 stray address untouched", int'(mem[12'hABC >> 1]), 0);
      chk("R10 size kept", wr_cnt, 1);
   endtask

   task automatic t_odd_addr();
      clear_stats();
      send(32'h0C00_0D01); send(32'h0B00_BEEF); send(32'h2300_0000);
      wait_done();
      chk("R2 bit 0 forced", first_wr_addr, 32'hD00);
      chk("R2 pixel at even address", int'(mem[12'hD00 >> 1]), 16'hBEEF);
   endtask

   task automatic t_wide();
      int bad = 0;
      clear_stats();
      send(32'h0C00_0000); send(32'h0E00_03FF); send(32'h0F00_0000);
      send(32'h0B00_5A5A); send(32'h2300_0002);
      wait_done();
      for (int i = 0; i < 1024; i++) if (mem[i] != 16'h5A5A) bad++;
      chk("R3 max width fill", bad, 0);
      chk("R7 max width busy", busy_cnt, 1024);
      chk("R9 irq with bit 1 only", irq_cnt, 1);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_fill_irq();
      t_fill_noirq();
      t_copy(32'h2100_0000, 32'h600, 32'h600, "forward");
      t_copy(32'h2100_0020, 32'h800, 32'h804, "hrev");
      t_copy(32'h2100_0010, 32'hA00, 32'hA20, "vrev");
      t_copy(32'h2100_0030, 32'hB00, 32'hB24, "both");
      t_unknown();
      t_odd_addr();
      t_wide();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule